// File: doc/BRIEF.md
# Manchester Frame Decoder with Preamble Sync

This block sits behind a clock and data recovery stage that hands over between one and three recovered line bits per clock. It keeps the line bits in arrival order across beats and watches them for the Manchester-coded sync word 0xAAD5. On a match it decodes the line bits that follow in pairs, packs the data bits into bytes and delivers a fixed number of payload bytes. After the last byte it goes back to hunting for the next sync word.

A frame on the wire is one training byte 0xAA, the sync word 0xAAD5 and the payload. The decoder does not need the training byte. It hunts at every line-bit offset, so the pair alignment comes from wherever the sync word lands. The input and the byte output are valid/ready streams. While an output byte is held back, the input stalls and no line bits are lost.

Top module: `mfd_frame_rx`

## Requirements
- R1: A beat is accepted when `in_valid` and `in_ready` are both high. It carries `in_cnt` line bits (0 to 3), and `in_bits[0]` is the earliest of them. Bit order is kept across beats, and a count of 0 adds no bits.
- R2: Each data bit uses two line bits. The pair 1 then 0 decodes to data 1, and the pair 0 then 1 decodes to data 0.
- R3: While hunting, the decoder locks when the 32 most recent line bits equal the Manchester coding of 0xAAD5, at any line-bit offset. The leading training byte is optional, and a different word (for example 0xAAD4) never locks.
- R4: After lock, exactly 4 payload bytes are assembled MSB first. Each byte appears once on `out_data` with `out_valid`.
- R5: The fourth byte carries `out_last`=1 and the earlier bytes carry 0. `frame_done` pulses in the cycle that byte is accepted. The decoder then hunts again, so bytes that follow without a new sync word produce no output.
- R6: During the payload, a pair of 00 or 11 is a code error. It sends the decoder back to hunting with the byte count cleared, so that frame never raises `out_last` or `frame_done`.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold steady and `in_ready` is low, so no input is taken. `in_ready` is high whenever no byte is pending.
- R8: After reset, including a reset in the middle of a frame, `out_valid` and `frame_done` are low and the decoder is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Decoder can take a beat |
| in_bits | input | 3 | Recovered line bits, bit 0 earliest |
| in_cnt | input | 2 | Number of valid bits in `in_bits` (0 to 3) |
| out_valid | output | 1 | Payload byte valid |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Byte is the last one of the frame |
| frame_done | output | 1 | Pulse when the last byte is accepted |

## Verification
The bench feeds whole frames behind 0 to 3 junk line bits and cuts the stream into beats of mixed sizes, including empty beats. A decoder that matched at only one pair alignment, or that reordered bits inside a beat, would lose sync or return wrong bytes on some of these vectors. It also tests a frame with no training byte, a near-miss sync word, payload-shaped bytes sent after a finished frame, and a code error inside a frame. Each of these shows up as a missing or extra `frame_done`, or as `out_last` on the wrong byte. Long output stalls and a mid-frame reset check that a held byte stays fixed, that no line bit is dropped while the input is stalled, and that no stale state survives reset.

// File: rtl/mfd_pkg.sv
package mfd_pkg;
  localparam int DATA_W = 8;
  typedef enum logic {ST_HUNT = 1'b0, ST_PAYLOAD = 1'b1} mfd_mode_t;
endpackage

// File: rtl/mfd_line_step.sv
// Consumes one line bit: sync hunt, pair decode, byte assembly.
module mfd_line_step
  import mfd_pkg::*;
#(
  parameter int SYNC_W = 16,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hAAD5,
  parameter int PAY_BYTES = 4,
  parameter int BC_W = 2,
  localparam int LW = 2 * SYNC_W
) (
  input  logic              en,
  input  logic              bit_in,
  input  mfd_mode_t         mode_i,
  input  logic [LW-1:0]     win_i,
  input  logic              hv_i,
  input  logic              hb_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [2:0]        nbit_i,
  input  logic [BC_W-1:0]   nbyte_i,
  output mfd_mode_t         mode_o,
  output logic [LW-1:0]     win_o,
  output logic              hv_o,
  output logic              hb_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [2:0]        nbit_o,
  output logic [BC_W-1:0]   nbyte_o,
  output logic              done_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              last_o
);
  logic [LW-1:0] pat;
  logic [LW-1:0] shifted;

  for (genvar g = 0; g < SYNC_W; g++) begin : g_pat
    assign pat[2*g+1] = SYNC_WORD[g];
    assign pat[2*g]   = ~SYNC_WORD[g];
  end

  assign shifted = {win_i[LW-2:0], bit_in};

  always_comb begin
    mode_o  = mode_i;
    win_o   = win_i;
    hv_o    = hv_i;
    hb_o    = hb_i;
    acc_o   = acc_i;
    nbit_o  = nbit_i;
    nbyte_o = nbyte_i;
    done_o  = 1'b0;
    byte_o  = {acc_i[DATA_W-2:0], hb_i};
    last_o  = 1'b0;
    if (en) begin
      if (mode_i == ST_HUNT) begin
        win_o = shifted;
        if (shifted == pat) begin
          mode_o  = ST_PAYLOAD;
          win_o   = '0;
          hv_o    = 1'b0;
          nbit_o  = '0;
          nbyte_o = '0;
        end
      end else if (!hv_i) begin
        hv_o = 1'b1;
        hb_o = bit_in;
      end else begin
        hv_o = 1'b0;
        if (hb_i == bit_in) begin
          mode_o  = ST_HUNT;
          win_o   = '0;
          nbit_o  = '0;
          nbyte_o = '0;
        end else begin
          acc_o  = {acc_i[DATA_W-2:0], hb_i};
          nbit_o = nbit_i + 3'd1;
          if (nbit_i == 3'd7) begin
            done_o = 1'b1;
            if (nbyte_i == BC_W'(PAY_BYTES - 1)) begin
              last_o  = 1'b1;
              mode_o  = ST_HUNT;
              win_o   = '0;
              nbyte_o = '0;
            end else begin
              nbyte_o = nbyte_i + BC_W'(1);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/mfd_out_reg.sv
// One-entry output holding register with valid/ready.
module mfd_out_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_last,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= ld_data;
      out_last  <= ld_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mfd_frame_rx.sv
module mfd_frame_rx
  import mfd_pkg::*;
#(
  parameter int MAX_BITS = 3,
  parameter int SYNC_W = 16,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hAAD5,
  parameter int PAY_BYTES = 4,
  localparam int CNT_W = $clog2(MAX_BITS + 1),
  localparam int BC_W = (PAY_BYTES > 1) ? $clog2(PAY_BYTES) : 1,
  localparam int LW = 2 * SYNC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [MAX_BITS-1:0] in_bits,
  input  logic [CNT_W-1:0]    in_cnt,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_last,
  output logic                frame_done
);
  mfd_mode_t         mode_q;
  logic [LW-1:0]     win_q;
  logic              hv_q, hb_q;
  logic [DATA_W-1:0] acc_q;
  logic [2:0]        nbit_q;
  logic [BC_W-1:0]   nbyte_q;

  mfd_mode_t         mode_c  [0:MAX_BITS];
  logic [LW-1:0]     win_c   [0:MAX_BITS];
  logic              hv_c    [0:MAX_BITS];
  logic              hb_c    [0:MAX_BITS];
  logic [DATA_W-1:0] acc_c   [0:MAX_BITS];
  logic [2:0]        nbit_c  [0:MAX_BITS];
  logic [BC_W-1:0]   nbyte_c [0:MAX_BITS];
  logic [MAX_BITS-1:0] done_c, last_c, en_c;
  logic [DATA_W-1:0] byte_c  [0:MAX_BITS-1];

  logic              take;
  logic              ld;
  logic [DATA_W-1:0] ld_data;
  logic              ld_last;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  assign mode_c[0]  = mode_q;
  assign win_c[0]   = win_q;
  assign hv_c[0]    = hv_q;
  assign hb_c[0]    = hb_q;
  assign acc_c[0]   = acc_q;
  assign nbit_c[0]  = nbit_q;
  assign nbyte_c[0] = nbyte_q;

  for (genvar g = 0; g < MAX_BITS; g++) begin : g_step
    assign en_c[g] = take && (in_cnt > CNT_W'(g));
    mfd_line_step #(
      .SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD),
      .PAY_BYTES(PAY_BYTES), .BC_W(BC_W)
    ) u_step (
      .en(en_c[g]), .bit_in(in_bits[g]),
      .mode_i(mode_c[g]), .win_i(win_c[g]), .hv_i(hv_c[g]), .hb_i(hb_c[g]),
      .acc_i(acc_c[g]), .nbit_i(nbit_c[g]), .nbyte_i(nbyte_c[g]),
      .mode_o(mode_c[g+1]), .win_o(win_c[g+1]), .hv_o(hv_c[g+1]), .hb_o(hb_c[g+1]),
      .acc_o(acc_c[g+1]), .nbit_o(nbit_c[g+1]), .nbyte_o(nbyte_c[g+1]),
      .done_o(done_c[g]), .byte_o(byte_c[g]), .last_o(last_c[g])
    );
  end

  // At most one byte can complete per beat (two data bits at most).
  always_comb begin
    ld      = 1'b0;
    ld_data = '0;
    ld_last = 1'b0;
    for (int i = 0; i < MAX_BITS; i++) begin
      if (done_c[i]) begin
        ld      = 1'b1;
        ld_data = byte_c[i];
        ld_last = last_c[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= ST_HUNT;
      win_q   <= '0;
      hv_q    <= 1'b0;
      hb_q    <= 1'b0;
      acc_q   <= '0;
      nbit_q  <= '0;
      nbyte_q <= '0;
    end else begin
      mode_q  <= mode_c[MAX_BITS];
      win_q   <= win_c[MAX_BITS];
      hv_q    <= hv_c[MAX_BITS];
      hb_q    <= hb_c[MAX_BITS];
      acc_q   <= acc_c[MAX_BITS];
      nbit_q  <= nbit_c[MAX_BITS];
      nbyte_q <= nbyte_c[MAX_BITS];
    end
  end

  mfd_out_reg #(.DW(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(ld), .ld_data(ld_data), .ld_last(ld_last),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  assign frame_done = out_valid && out_ready && out_last;
endmodule

// File: rtl/mfd_frame_rx_chk.sv
module mfd_frame_rx_chk #(
  parameter int MAX_BITS = 3,
  parameter int CNT_W = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [MAX_BITS-1:0] in_bits,
  input logic [CNT_W-1:0]    in_cnt,
  input logic                out_valid,
  input logic                out_ready,
  input logic [7:0]          out_data,
  input logic                out_last,
  input logic                frame_done
);
  // R7: a stalled byte holds steady
  a_r7_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  // R7: no input taken while a byte is stalled
  a_r7_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R7: ready when nothing pending
  a_r7_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R5: frame_done only with an accepted last byte
  a_r5_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> out_valid && out_last && out_ready);
  // R5: after a frame the decoder hunts, so no byte follows at once
  a_r5_hunt_after: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !out_valid);
  // R1: a new byte only appears after an accepted input beat
  a_r1_byte_from_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_cnt != '0));
  // R4: a byte leaves only when a valid one is held
  a_r4_valid_data: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  logic unused_ok;
  assign unused_ok = ^in_bits;
endmodule

bind mfd_frame_rx mfd_frame_rx_chk #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_bits(in_bits), .in_cnt(in_cnt), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .frame_done(frame_done)
);

// File: tb/sim_mfd_frame_rx.sv
`timescale 1ns/1ps
module sim_mfd_frame_rx;
  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [2:0] in_bits = '0;
  logic [1:0] in_cnt = '0;
  logic out_valid, out_last, frame_done;
  logic out_ready = 1;
  logic [7:0] out_data;

  always #10 clk = ~clk;

  mfd_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bits(in_bits), .in_cnt(in_cnt), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .frame_done(frame_done)
  );

  int nchk = 0, nfail = 0;
  logic ls [0:1023];
  int ls_len = 0, ls_pos = 0;
  logic [7:0] rx_b [0:63];
  logic rx_l [0:63];
  int rx_n = 0, fd_n = 0;
  int rdy_mode = 0;

  // payload[39:8], junk bits [7:6], beat pattern [5:3], ready mode [2:0]
  localparam logic [39:0] VEC [0:5] = '{
    {32'hAABBCCDD, 2'd0, 3'd0, 3'd0},
    {32'h0123FF00, 2'd1, 3'd1, 3'd0},
    {32'hD5AAD5AA, 2'd2, 3'd2, 3'd1},
    {32'h80017EFE, 2'd3, 3'd3, 3'd0},
    {32'h5A5AA5A5, 2'd1, 3'd4, 3'd1},
    {32'hFFFFFFFF, 2'd0, 3'd1, 3'd1}
  };

  always @(posedge clk) begin
    #3;
    if (rdy_mode == 0) out_ready = 1;
    else if (rdy_mode == 1) out_ready = ~out_ready;
    else out_ready = 0;
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && rx_n < 64) begin
      rx_b[rx_n] = out_data;
      rx_l[rx_n] = out_last;
      rx_n++;
    end
    if (rst_n && frame_done) fd_n++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr();
    ls_len = 0; ls_pos = 0; rx_n = 0; fd_n = 0;
  endtask

  task automatic put_bit(input logic b);
    ls[ls_len] = b; ls_len++;
  endtask

  task automatic put_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin put_bit(b[i]); put_bit(~b[i]); end
  endtask

  function automatic int cnt_of(input int pat, input int k);
    case (pat)
      0: return 2;
      1: return (k % 3) + 1;
      2: return 3;
      3: return 1;
      default: return (k % 3 == 0) ? 3 : ((k % 3 == 1) ? 0 : 1);
    endcase
  endfunction

  // R1: feed line bits, bit 0 of each beat first
  task automatic feed(input int pat);
    int k = 0, guard = 0;
    while (ls_pos < ls_len && guard < 2000) begin
      int c;
      bit acc;
      c = cnt_of(pat, k);
      if (c > ls_len - ls_pos) c = ls_len - ls_pos;
      @(negedge clk);
      in_valid = 1;
      in_cnt = 2'(c);
      in_bits = '0;
      for (int j = 0; j < c; j++) in_bits[j] = ls[ls_pos + j];
      #1;
      acc = in_ready;
      @(posedge clk);
      if (acc) begin ls_pos += c; k++; end
      guard++;
    end
    @(negedge clk);
    in_valid = 0;
    repeat (12) @(negedge clk);
  endtask

  task automatic put_frame(input logic [31:0] p, input bit train);
    if (train) put_byte(8'hAA);
    put_byte(8'hAA); put_byte(8'hD5);
    for (int i = 3; i >= 0; i--) put_byte(p[8*i +: 8]);
    for (int i = 0; i < 4; i++) put_bit(0);
  endtask

  initial begin
    #(20 * 150000);
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    nchk++; nfail++;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(out_valid == 0, "R8 out_valid after reset", out_valid, 0);
    chk(frame_done == 0, "R8 frame_done after reset", frame_done, 0);
    chk(in_ready == 1, "R7 in_ready idle", in_ready, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // Table: R1 R2 R3 R4 R5 R7 under varied beats, offsets, stalls
    for (int v = 0; v < 6; v++) begin
      logic [31:0] p;
      p = VEC[v][39:8];
      clr();
      rdy_mode = int'(VEC[v][2:0]);
      for (int j = 0; j < int'(VEC[v][7:6]); j++) put_bit(j[0] ? 1'b0 : 1'b1);
      put_frame(p, 1);
      feed(int'(VEC[v][5:3]));
      rdy_mode = 0;
      repeat (4) @(negedge clk);
      chk(rx_n == 4, "R4 byte count", rx_n, 4);
      for (int i = 0; i < 4; i++) begin
        chk(rx_b[i] == p[8*(3-i) +: 8], "R2 R4 byte value", rx_b[i], p[8*(3-i) +: 8]);
        chk(rx_l[i] == (i == 3), "R5 last flag", rx_l[i], (i == 3));
      end
      chk(fd_n == 1, "R5 frame_done count", fd_n, 1);
    end

    // R3: no training byte still locks
    clr(); put_frame(32'h11223344, 0); feed(0);
    chk(rx_n == 4 && rx_b[0] == 8'h11, "R3 sync without training", rx_b[0], 8'h11);

    // R3: near-miss sync word never locks
    clr(); put_byte(8'hAA); put_byte(8'hAA); put_byte(8'hD4);
    put_byte(8'h12); put_byte(8'h34); put_byte(8'h56); put_byte(8'h78); feed(1);
    chk(rx_n == 0, "R3 wrong sync ignored", rx_n, 0);

    // R5: after a frame, payload without sync gives nothing
    clr(); put_frame(32'hCAFEF00D, 1);
    put_byte(8'h01); put_byte(8'h02); put_byte(8'h03); put_byte(8'h04); put_byte(8'h05);
    feed(2);
    chk(rx_n == 4, "R5 hunt after frame", rx_n, 4);
    chk(fd_n == 1, "R5 single frame_done", fd_n, 1);

    // R6: code error mid-frame, then full frame
    clr(); put_byte(8'hAA); put_byte(8'hAA); put_byte(8'hD5);
    put_byte(8'h9A); put_byte(8'hBC); put_bit(1); put_bit(1);
    put_byte(8'hEE); put_byte(8'hEE);
    put_frame(32'h10203040, 1); feed(1);
    chk(rx_n == 6, "R6 bytes around error", rx_n, 6);
    chk(fd_n == 1, "R6 no frame_done for broken frame", fd_n, 1);
    chk(rx_l[1] == 0 && rx_l[5] == 1, "R6 last position", {rx_l[1], rx_l[5]}, 2'b01);
    chk(rx_b[2] == 8'h10, "R6 new frame first byte", rx_b[2], 8'h10);

    // R7: long stall holds byte and input
    clr(); put_frame(32'h77665544, 1);
    rdy_mode = 2;
    feed(0);
    chk(out_valid == 1 && out_data == 8'h77, "R7 held byte", out_data, 8'h77);
    chk(in_ready == 0, "R7 input stalled", in_ready, 0);
    chk(rx_n == 0, "R7 nothing accepted", rx_n, 0);
    rdy_mode = 0;
    feed(0);
    chk(rx_n == 4 && rx_b[3] == 8'h44, "R7 no bits lost", rx_b[3], 8'h44);

    // R8: reset mid-frame
    clr(); put_byte(8'hAA); put_byte(8'hAA); put_byte(8'hD5); put_byte(8'h55); put_bit(1);
    feed(0);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    chk(out_valid == 0, "R8 mid-frame reset", out_valid, 0);
    rst_n = 1;
    clr(); put_byte(8'h99); put_byte(8'h88); put_byte(8'h77); put_byte(8'h66);
    put_frame(32'h0BADBEEF, 1); feed(1);
    chk(rx_n == 4 && rx_b[0] == 8'h0B, "R8 clean restart", rx_b[0], 8'h0B);
    chk(fd_n == 1, "R8 one frame after reset", fd_n, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule